// File: doc/BRIEF.md
# Serial Video Header Hunter and Word Aligner

This block sits directly behind the line decoder of a serial digital video receiver. It runs on the serial bit clock and takes one decoded bit per clock, together with a flag that marks the bit as valid. It gathers the bits into 10-bit parallel words and issues a word strobe once for every ten valid bits, which is one tenth of the bit rate (for example, 27 MHz words from a 270 Mb/s stream).

A receiver that has just come up does not know where the word boundaries are. The block searches the bitstream for the timing reference preamble that opens every active-video start and end marker. In arrival order, that preamble is a run of ten 1s followed by twenty 0s, which is the word sequence 3FF, 000, 000 sent least significant bit first. When the twentieth 0 arrives, the divide-by-ten word timing is forced back to its starting point in the same clock. The word that ends on that bit is emitted at once, and every later word then lines up with the header.

Each header found is reported by flipping the level of the `h_level` output, not by a pulse. Downstream logic can therefore detect a header by comparing the level with its previous value, at any sampling rate.

Top module: `sdi_word_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (`word_out`, `word_stb`, `h_level`) are 0 after that edge. The word phase also restarts, so the first strobe after reset follows the tenth valid bit.
- R2: A header is found when the last thirty valid bits, in arrival order, are ten 1s followed by twenty 0s. `h_level` inverts in the clock after the edge that accepts the twentieth 0.
- R3: A run of more than ten 1s before the twenty 0s still counts as a header. Only the final ten 1s matter.
- R4: A 1 arriving among the twenty 0s stops the header search, as does a run of fewer than ten 1s before them. Neither case inverts `h_level`.
- R5: With no header present, `word_strobe` is high for exactly one clock after every tenth valid bit.
- R6: At a strobe, `word_out` holds the last ten valid bits, with bit 0 the earliest received and bit 9 the latest. Between strobes `word_out` does not change.
- R7: At the bit that completes a header, a strobe is issued whatever the current phase, and the ten-bit count restarts from that bit. The next strobe follows ten valid bits later.
- R8: When a header completes exactly on an existing word boundary, only one strobe is issued and the word phase is unchanged.
- R9: A clock with `bit_valid` low changes neither the word phase nor the header search state, and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Decoded serial data bit |
| bit_valid | input | 1 | Marks `bit_in` as a valid bit for this clock |
| word_out | output | 10 | Parallel word, bit 0 received first |
| word_stb | output | 1 | One-clock strobe marking a new `word_out` |
| h_level | output | 1 | Inverts once per header found |

## Verification
A wrong word phase shows up within ten valid bits: a strobe arrives early or late, or `word_out` carries a rotated word. A header search stuck in the wrong state shows up at the end of the next header as a missing or extra inversion of `h_level`, or at the next broken run of 0s as a false inversion. Since the reference model is compared on every clock, any such slip is caught in the cycle where it first reaches a port. Directed sequences place headers both off and on the existing boundary, with longer runs of 1s, short runs of 1s, and a 1 inside the zero run.

// File: rtl/sdi_align_pkg.sv
package sdi_align_pkg;
  typedef enum logic [0:0] {
    HUNT_ONES  = 1'b0,
    HUNT_ZEROS = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/trs_hunter.sv
module trs_hunter
  import sdi_align_pkg::*;
#(
  parameter int ONES_LEN  = 10,
  parameter int ZEROS_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  output logic found
);
  localparam int OW = $clog2(ONES_LEN + 1);
  localparam int ZW = $clog2(ZEROS_LEN + 1);
  localparam logic [OW-1:0] ONES_MAX  = OW'(ONES_LEN);
  localparam logic [ZW-1:0] ZERO_LAST = ZW'(ZEROS_LEN - 1);

  hunt_state_e    state;
  logic [OW-1:0]  ones_cnt;   // run of 1s; cleared whenever the data is low
  logic [ZW-1:0]  zero_cnt;   // zeros seen after a long enough run of 1s

  assign found = bit_valid && (state == HUNT_ZEROS) && !bit_in && (zero_cnt == ZERO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= HUNT_ONES;
      ones_cnt <= '0;
      zero_cnt <= '0;
    end else if (bit_valid) begin
      case (state)
        HUNT_ONES: begin
          if (bit_in) begin
            if (ones_cnt != ONES_MAX) ones_cnt <= ones_cnt + 1'b1;
          end else begin
            ones_cnt <= '0;
            if (ones_cnt == ONES_MAX) begin
              state    <= HUNT_ZEROS;
              zero_cnt <= ZW'(1);
            end
          end
        end
        HUNT_ZEROS: begin
          if (bit_in) begin
            state    <= HUNT_ONES;
            ones_cnt <= OW'(1);
            zero_cnt <= '0;
          end else if (zero_cnt == ZERO_LAST) begin
            state    <= HUNT_ONES;
            zero_cnt <= '0;
          end else begin
            zero_cnt <= zero_cnt + 1'b1;
          end
        end
        default: state <= HUNT_ONES;
      endcase
    end
  end

  // R4: a 1 in the zero run drops the search back to hunting for 1s
  p_break_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && state == HUNT_ZEROS) |=> (state == HUNT_ONES));

  // R9: idle clocks leave the search untouched
  p_hunt_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(state) && $stable(ones_cnt) && $stable(zero_cnt)));
endmodule

// File: rtl/word_divider.sv
module word_divider #(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic realign,
  output logic boundary
);
  localparam int PW = $clog2(WORD_W);
  localparam logic [PW-1:0] LAST = PW'(WORD_W - 1);

  logic [PW-1:0] phase;

  assign boundary = bit_valid && (realign || phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (boundary)  phase <= '0;
    else if (bit_valid) phase <= phase + 1'b1;
  end

  // R5: phase never leaves the ten-bit range
  p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  // R9: no valid bit, no phase movement
  p_phase_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(phase));

  // R7: a realign always restarts the count
  p_realign_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && realign) |=> (phase == '0));
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic              boundary,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb
);
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] sr_next;

  // newest bit enters at the top, so bit 0 is the oldest after WORD_W shifts
  assign sr_next = {bit_in, sr[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      word_out <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= boundary;
      if (bit_valid) sr <= sr_next;
      if (boundary)  word_out <= sr_next;
    end
  end

  // R6: the parallel word only moves together with the strobe
  p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !word_stb |-> $stable(word_out));
endmodule

// File: rtl/sdi_word_aligner.sv
module sdi_word_aligner #(
  parameter int WORD_W    = 10,
  parameter int ONES_LEN  = 10,
  parameter int ZEROS_LEN = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb,
  output logic              h_level
);
  logic found;
  logic boundary;

  trs_hunter #(.ONES_LEN(ONES_LEN), .ZEROS_LEN(ZEROS_LEN)) u_hunt (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid), .found(found)
  );

  word_divider #(.WORD_W(WORD_W)) u_div (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .realign(found), .boundary(boundary)
  );

  deser_shift #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .boundary(boundary), .word_out(word_out), .word_stb(word_stb)
  );

  always_ff @(posedge clk) begin
    if (rst)        h_level <= 1'b0;
    else if (found) h_level <= ~h_level;
  end

  // R2: each header found inverts the level in the next clock
  p_h_flip_r2: assert property (@(posedge clk) disable iff (rst)
    found |=> (h_level != $past(h_level)));

  // R2: the level never moves without a header
  p_h_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !found |=> $stable(h_level));

  // R7: a header always yields a strobe
  p_stb_on_found_r7: assert property (@(posedge clk) disable iff (rst)
    found |=> word_stb);
endmodule

// File: tb/sdi_word_aligner_test.sv
module sdi_word_aligner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       bit_valid = 1'b0;
  logic [9:0] word_out;
  logic       word_stb;
  logic       h_level;

  int n_chk = 0;
  int n_bad = 0;
  int n_stb = 0;
  string cur_req = "R1";

  // behavioural reference
  bit   hist[$];
  int   m_phase = 0;
  logic [9:0] m_word = '0;
  logic [9:0] m_sr = '0;
  logic m_stb = 1'b0;
  logic m_h = 1'b0;

  always #2.5 clk = ~clk;

  sdi_word_aligner uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .word_out(word_out), .word_stb(word_stb), .h_level(h_level)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit header_seen();
    if (hist.size() < 30) return 1'b0;
    for (int i = 0; i < 10; i++) if (hist[i] != 1'b1) return 1'b0;
    for (int i = 10; i < 30; i++) if (hist[i] != 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic compare_all();
    check(word_stb == m_stb, cur_req, "word_stb", word_stb, m_stb);
    check(word_out == m_word, cur_req, "word_out", word_out, m_word);
    check(h_level == m_h, cur_req, "h_level", h_level, m_h);
    if (word_stb) n_stb++;
  endtask

  task automatic step(input bit v, input bit b);
    bit det;
    bit_valid = v;
    bit_in    = b;
    @(posedge clk);
    #1;
    m_stb = 1'b0;
    if (v) begin
      hist.push_back(b);
      if (hist.size() > 30) void'(hist.pop_front());
      det  = header_seen();
      m_sr = {b, m_sr[9:1]};
      if (det || m_phase == 9) begin
        m_stb   = 1'b1;
        m_word  = m_sr;
        m_phase = 0;
      end else begin
        m_phase++;
      end
      if (det) m_h = ~m_h;
    end
    bit_valid = 1'b0;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    hist.delete();
    m_phase = 0; m_word = '0; m_sr = '0; m_stb = 1'b0; m_h = 1'b0;
    cur_req = "R1";
    compare_all();
    check(word_out == 10'h000 && !word_stb && !h_level, "R1", "reset outputs",
          {word_out, word_stb, h_level}, 0);
  endtask

  task automatic send_run(input bit b, input int n);
    for (int i = 0; i < n; i++) step(1'b1, b);
  endtask

  task automatic send_random(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) step(1'b0, 1'($urandom));
      step(1'b1, 1'($urandom % 2));
    end
  endtask

  task automatic send_header();
    send_run(1'b1, 10);
    send_run(1'b0, 20);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic h0;
    int s0;
    do_reset();

    // R1: first strobe only after the tenth valid bit
    cur_req = "R1";
    s0 = n_stb;
    send_random(9, 1'b0);
    check(n_stb == s0, "R1", "strobes before tenth bit", n_stb - s0, 0);
    send_random(1, 1'b0);
    check(n_stb == s0 + 1, "R1", "strobe at tenth bit", n_stb - s0, 1);

    // R5 / R6: free-running words on random data
    cur_req = "R5";
    send_random(60, 1'b0);
    cur_req = "R6";
    step(1'b1, 1); step(1'b1, 0); step(1'b1, 0); step(1'b1, 1); step(1'b1, 1);
    step(1'b1, 0); step(1'b1, 1); step(1'b1, 0); step(1'b1, 0); step(1'b1, 0);
    check(word_out == 10'h05_9 && word_stb, "R6", "bit order", word_out, 10'h059);

    // R9: gaps in the valid flag
    cur_req = "R9";
    send_random(80, 1'b1);
    s0 = n_stb;
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1);
    check(n_stb == s0, "R9", "strobes during idle", n_stb - s0, 0);

    // R7: header off the current boundary
    cur_req = "R7";
    send_run(1'b0, 3);
    h0 = h_level;
    send_header();
    check(h_level == ~h0, "R7", "h after misaligned header", h_level, ~h0);
    check(word_stb && word_out == 10'h000, "R7", "strobe at header end",
          {word_stb, word_out}, 11'h400);
    s0 = n_stb;
    send_random(10, 1'b0);
    check(n_stb == s0 + 1, "R7", "next strobe ten bits later", n_stb - s0, 1);

    // R8: header on the established boundary, random valid gaps around it
    cur_req = "R8";
    send_random(17, 1'b1);
    send_run(1'b0, 3);
    h0 = h_level;
    s0 = n_stb;
    send_header();
    check(n_stb == s0 + 3, "R8", "strobes across aligned header", n_stb - s0, 3);
    check(h_level == ~h0, "R8", "h after aligned header", h_level, ~h0);

    // R2: plain header with idle clocks inside it
    cur_req = "R2";
    h0 = h_level;
    for (int i = 0; i < 10; i++) begin step(1'b0, 1'b0); step(1'b1, 1'b1); end
    for (int i = 0; i < 20; i++) begin step(1'b0, 1'b1); step(1'b1, 1'b0); end
    check(h_level == ~h0, "R2", "h after gapped header", h_level, ~h0);

    // R3: long run of 1s
    cur_req = "R3";
    h0 = h_level;
    send_run(1'b1, 17);
    send_run(1'b0, 20);
    check(h_level == ~h0, "R3", "h after long ones run", h_level, ~h0);

    // R4: too few 1s, and a 1 inside the zeros
    cur_req = "R4";
    h0 = h_level;
    send_run(1'b0, 2);
    send_run(1'b1, 9);
    send_run(1'b0, 25);
    check(h_level == h0, "R4", "h after nine ones", h_level, h0);
    send_run(1'b1, 10);
    send_run(1'b0, 12);
    send_run(1'b1, 1);
    send_run(1'b0, 19);
    check(h_level == h0, "R4", "h after broken zero run", h_level, h0);
    send_run(1'b0, 5);
    check(h_level == h0, "R4", "h after trailing zeros", h_level, h0);

    // mixed traffic, then reset mid-stream
    cur_req = "R5";
    send_random(200, 1'b1);
    send_header();
    send_random(95, 1'b1);
    do_reset();
    cur_req = "R1";
    send_random(25, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule